// File: doc/BRIEF.md
# Banked GPIO Interrupt Line Multiplexer

This block collects the per-pin interrupt lines of three GPIO banks and places them onto a fixed set of interrupt-controller inputs. By default, it has 14 pins in bank 0, 24 in bank 1 and 32 in bank 2. There are fewer controller inputs than pins. Bank 0 and bank 1 own the direct lines by default. Bank 2 can take over any of the low controller lines, one bit at a time, through a routing register.

A pin that loses its direct line still reaches the controller. Each bank has one collector line, which is the OR of every pin in that bank that currently has no direct route. Software can therefore route latency-sensitive bank 2 pins directly and still service the displaced pins through the collector lines. All controller lines are registered.

Top module: `gpio_irq_mux`

## Requirements
- R1: While `rst_n` is low, `route_rdata` reads 0 and every bit of `line_irq` is 0. The routing register holds 0 after reset, so bank 2 has no direct lines.
- R2: A cycle with `route_we` high loads `route_wdata` into the routing register, and `route_rdata` shows the new value after that clock edge. While `route_we` is low, the register keeps its value.
- R3: For a line i in 0..13 whose routing bit i is 0, `line_irq[i]` carries bank 0 pin i.
- R4: For a line i in 14..31 whose routing bit i is 0, `line_irq[i]` carries bank 1 pin i-14.
- R5: For a line i in 0..31 whose routing bit i is 1, `line_irq[i]` carries bank 2 pin i instead of its default source.
- R6: `line_irq[37:32]` always carry bank 1 pins 18..23, whatever the routing register holds.
- R7: `line_irq[38]` is the OR of the bank 0 pins j whose routing bit j is 1.
- R8: `line_irq[39]` is the OR of the bank 1 pins j in 0..17 whose routing bit j+14 is 1. Bank 1 pins 18..23 never reach this line.
- R9: `line_irq[40]` is the OR of the bank 2 pins j whose routing bit j is 0.
- R10: Every output is registered. A change on a pin line appears on `line_irq` one clock edge later and not earlier. A routing write affects `line_irq` at the edge after the one that loads the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| b0_irq | input | 14 | Bank 0 pin interrupt lines |
| b1_irq | input | 24 | Bank 1 pin interrupt lines |
| b2_irq | input | 32 | Bank 2 pin interrupt lines |
| route_we | input | 1 | Routing register write enable |
| route_wdata | input | 32 | Routing register write data |
| route_rdata | output | 32 | Routing register read data |
| line_irq | output | 41 | Interrupt-controller lines |

## Verification
On every cycle, the assertions compare each group of controller lines with the pin and routing values of the previous cycle. This covers the per-line selection, the fixed upper lines of bank 1, the three collector ORs, the register write, and the reset values. These checks do not show that the mapping is right for every individual pin. The bench provides that coverage. It routes each bank 2 bit in turn and drives each of the 70 pins alone under several routing patterns. It also checks that a displaced pin moves onto its collector line, and that no output moves before its clock edge.

// File: rtl/gpio_irq_mux.sv
`timescale 1ns/1ps
module gpio_irq_mux #(
  parameter int N0 = 14,
  parameter int N1 = 24,
  parameter int N2 = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N0-1:0]       b0_irq,
  input  logic [N1-1:0]       b1_irq,
  input  logic [N2-1:0]       b2_irq,
  input  logic                route_we,
  input  logic [N2-1:0]       route_wdata,
  output logic [N2-1:0]       route_rdata,
  output logic [N0+N1+2:0]    line_irq
);
  localparam int NDIR = N0 + N1;
  localparam int NOUT = NDIR + 3;

  logic [N2-1:0]   route_q;
  logic [NDIR-1:0] dflt;
  logic [NDIR-1:0] taken;
  logic [NDIR-1:0] dir_next;
  logic            or0, or1, or2;
  logic [NOUT-1:0] line_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        route_q <= '0;
    else if (route_we) route_q <= route_wdata;

  assign dflt = {b1_irq, b0_irq};

  for (genvar i = 0; i < NDIR; i++) begin : g_line
    if (i < N2) begin : g_sel
      assign taken[i]    = route_q[i];
      assign dir_next[i] = route_q[i] ? b2_irq[i] : dflt[i];
    end else begin : g_fix
      assign taken[i]    = 1'b0;
      assign dir_next[i] = dflt[i];
    end
  end

  assign or0 = |(b0_irq & taken[N0-1:0]);
  assign or1 = |(b1_irq & taken[NDIR-1:N0]);
  assign or2 = |(b2_irq & ~route_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) line_q <= '0;
    else        line_q <= {or2, or1, or0, dir_next};

  assign line_irq    = line_q;
  assign route_rdata = route_q;
endmodule

// File: rtl/gpio_irq_mux_chk.sv
`timescale 1ns/1ps
module gpio_irq_mux_chk #(
  parameter int N0 = 14,
  parameter int N1 = 24,
  parameter int N2 = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N0-1:0]    b0_irq,
  input logic [N1-1:0]    b1_irq,
  input logic [N2-1:0]    b2_irq,
  input logic             route_we,
  input logic [N2-1:0]    route_wdata,
  input logic [N2-1:0]    route_rdata,
  input logic [N0+N1+2:0] line_irq
);
  localparam int NDIR = N0 + N1;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |-> (route_rdata == '0 && line_irq == '0)); // R1
  AST_ROUTE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) route_we |=> route_rdata == $past(route_wdata)); // R2
  AST_ROUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !route_we |=> $stable(route_rdata)); // R2
  AST_LOW_LINES: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=>
    line_irq[N0-1:0] == (($past(b0_irq) & ~$past(route_rdata[N0-1:0])) | ($past(b2_irq[N0-1:0]) & $past(route_rdata[N0-1:0])))); // R3
  AST_MID_LINES: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=>
    line_irq[N2-1:N0] == (($past(b1_irq[N2-N0-1:0]) & ~$past(route_rdata[N2-1:N0])) | ($past(b2_irq[N2-1:N0]) & $past(route_rdata[N2-1:N0])))); // R5
  AST_FIXED_LINES: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=>
    line_irq[NDIR-1:N2] == $past(b1_irq[N1-1:N2-N0])); // R6
  AST_COLLECT_B0: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=>
    line_irq[NDIR] == |($past(b0_irq) & $past(route_rdata[N0-1:0]))); // R7
  AST_COLLECT_B1: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=>
    line_irq[NDIR+1] == |($past(b1_irq[N2-N0-1:0]) & $past(route_rdata[N2-1:N0]))); // R8
  AST_COLLECT_B2: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=>
    line_irq[NDIR+2] == |($past(b2_irq) & ~$past(route_rdata))); // R9
endmodule

bind gpio_irq_mux gpio_irq_mux_chk #(.N0(N0), .N1(N1), .N2(N2)) u_chk (
  .clk(clk), .rst_n(rst_n), .b0_irq(b0_irq), .b1_irq(b1_irq), .b2_irq(b2_irq),
  .route_we(route_we), .route_wdata(route_wdata), .route_rdata(route_rdata),
  .line_irq(line_irq)
);

// File: tb/gpio_irq_mux_tb.sv
`timescale 1ns/1ps
module gpio_irq_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] b0_irq = '0;
  logic [23:0] b1_irq = '0;
  logic [31:0] b2_irq = '0;
  logic        route_we = 1'b0;
  logic [31:0] route_wdata = '0;
  logic [31:0] route_rdata;
  logic [40:0] line_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] ctl_m = '0;
  logic [40:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  gpio_irq_mux u_dut (
    .clk(clk), .rst_n(rst_n), .b0_irq(b0_irq), .b1_irq(b1_irq), .b2_irq(b2_irq),
    .route_we(route_we), .route_wdata(route_wdata), .route_rdata(route_rdata),
    .line_irq(line_irq)
  );

  function automatic logic [40:0] model(input logic [31:0] c, input logic [69:0] p);
    logic [40:0] e = '0;
    for (int i = 0; i < 32; i++)
      e[i] = c[i] ? p[38+i] : (i < 14 ? p[i] : p[i]);
    for (int i = 32; i < 38; i++) e[i] = p[i];
    for (int j = 0; j < 14; j++) e[38] = e[38] | (p[j] & c[j]);
    for (int j = 0; j < 18; j++) e[39] = e[39] | (p[14+j] & c[14+j]);
    for (int j = 0; j < 32; j++) e[40] = e[40] | (p[38+j] & ~c[j]);
    return e;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_lines(input logic [40:0] e);
    chk("R3/R4/R5 lines 0..31", {32'd0, line_irq[31:0]}, {32'd0, e[31:0]});
    chk("R6 lines 32..37", {58'd0, line_irq[37:32]}, {58'd0, e[37:32]});
    chk("R7 bank0 collector", {63'd0, line_irq[38]}, {63'd0, e[38]});
    chk("R8 bank1 collector", {63'd0, line_irq[39]}, {63'd0, e[39]});
    chk("R9 bank2 collector", {63'd0, line_irq[40]}, {63'd0, e[40]});
  endtask

  task automatic apply(input logic [69:0] p);
    logic [40:0] e;
    @(negedge clk);
    {b2_irq, b1_irq, b0_irq} = p;
    #1;
    chk("R10 no change before edge", {23'd0, line_irq}, {23'd0, prev_exp});
    e = model(ctl_m, p);
    @(negedge clk);
    chk_lines(e);
    prev_exp = e;
  endtask

  task automatic wr(input logic [31:0] c);
    logic [69:0] p;
    @(negedge clk);
    route_we = 1'b1;
    route_wdata = c;
    @(negedge clk);
    route_we = 1'b0;
    route_wdata = ~c;
    chk("R2 route readback", {32'd0, route_rdata}, {32'd0, c});
    chk("R10 write not yet on lines", {23'd0, line_irq}, {23'd0, prev_exp});
    p = {b2_irq, b1_irq, b0_irq};
    ctl_m = c;
    prev_exp = model(c, p);
    @(negedge clk);
    chk("R2 hold without write", {32'd0, route_rdata}, {32'd0, c});
    chk_lines(prev_exp);
  endtask

  task automatic sweep(input logic [31:0] c);
    logic [69:0] lf;
    wr(c);
    apply('0);
    apply({70{1'b1}});
    for (int k = 0; k < 70; k++) apply(70'd1 << k);
    lf = 70'h2_5A3C_F019_77E1_C3B4 ^ {c, c, 6'd0};
    for (int k = 0; k < 6; k++) begin
      lf = {lf[68:0], lf[69] ^ lf[66] ^ lf[5]};
      apply(lf);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset route", {32'd0, route_rdata}, 64'd0);
    chk("R1 reset lines", {23'd0, line_irq}, 64'd0);
    b0_irq = '1; b1_irq = '1; b2_irq = '1; route_we = 1'b1; route_wdata = '1;
    @(negedge clk);
    chk("R1 reset holds route", {32'd0, route_rdata}, 64'd0);
    chk("R1 reset holds lines", {23'd0, line_irq}, 64'd0);
    route_we = 1'b0; b0_irq = '0; b1_irq = '0; b2_irq = '0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 route after reset", {32'd0, route_rdata}, 64'd0);
    sweep(32'h0);
    sweep(32'hFFFF_FFFF);
    for (int b = 0; b < 32; b++) sweep(32'd1 << b);
    sweep(32'h0000_3FFF);
    sweep(32'hFFFF_C000);
    sweep(32'hA5A5_5A5A);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule